// File: doc/BRIEF.md
# Carry-Chaining Integer Add/Subtract Unit

This block is a 64-bit integer add and subtract unit that keeps a small flag register holding carry, zero, negative and overflow. Four operations are supported: plain add, plain subtract, add-with-carry and subtract-with-carry. Every operation goes through a single adder. Subtraction feeds the inverted second operand into that adder. The flag register holds the carry-out of the adder exactly as produced, with no inversion. A set carry after a subtract therefore means that no borrow occurred.

Because the stored carry keeps the same sense for add and subtract, multi-word arithmetic needs no carry-complement step between words. A wide subtraction is done as a plain subtract on the least significant word, followed by subtract-with-carry on each higher word. A wide addition uses add and then add-with-carry in the same way. An operation is launched by pulsing `valid_i` for one clock. The result and the new flags appear in registers one clock later. Flags are written only when `flag_we_i` is high during the launch.

Top module: `addc_unit`

## Requirements
- R1: During and immediately after reset, `valid_o`, `result_o`, `carry_o`, `zero_o`, `neg_o` and `ovf_o` are all 0.
- R2: Opcode 2'b00 (add) gives `result_o` = (a + b) mod 2^64. The carry is bit 64 of the unbounded sum a + b.
- R3: Opcode 2'b01 (subtract) gives `result_o` = a + ~b + 1 mod 2^64. The carry is the raw carry-out of that sum, so it is 1 exactly when a >= b unsigned.
- R4: Opcode 2'b10 (add-with-carry) gives a + b + C, where C is the stored carry flag at launch. The carry-out of that sum becomes the new carry.
- R5: Opcode 2'b11 (subtract-with-carry) gives a + ~b + C, where C is the stored carry flag at launch. The raw carry-out becomes the new carry, with no inversion.
- R6: When flags are written, `zero_o` is 1 exactly when the 64-bit result is 0, and `neg_o` equals bit 63 of the result.
- R7: When flags are written, `ovf_o` is 1 exactly when bit 63 of a equals bit 63 of the second adder input (b for opcodes 00 and 10, ~b for opcodes 01 and 11) and bit 63 of the result differs from them.
- R8: A launch with `flag_we_i` = 0 updates `result_o` and leaves all four flags unchanged.
- R9: `valid_o` is high exactly on the cycle after a launch. Without a launch, `result_o` and the flags hold their values.
- R10: A 128-bit subtraction done as subtract on the low word followed by subtract-with-carry on the high word equals the 128-bit difference mod 2^128. The same holds for a 128-bit addition done as add followed by add-with-carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Launch an operation this cycle |
| op_i | input | 2 | Opcode: 00 add, 01 subtract, 10 add-with-carry, 11 subtract-with-carry |
| flag_we_i | input | 1 | Write the flags for this launch |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result registered from the previous cycle's launch |
| result_o | output | 64 | Registered result |
| carry_o | output | 1 | Stored carry flag (1 = carry out / no borrow) |
| zero_o | output | 1 | Stored zero flag |
| neg_o | output | 1 | Stored negative flag |
| ovf_o | output | 1 | Stored signed-overflow flag |

## Verification
The result, `valid_o` and all four flags become visible one clock after the rising edge that samples a launch. The carry read by add-with-carry and subtract-with-carry is the stored value at that same edge. Each directed task drives its inputs on a falling edge and removes the launch on the next falling edge. It then samples the outputs, half a period after the edge that registered them. Chained word sequences rely on the carry being held through the idle cycle between launches. The bench checks this holding against a 128-bit reference difference or sum.

// File: rtl/addc_pkg.sv
package addc_pkg;
    localparam int unsigned DATA_W = 64;

    // Bit 0 selects an inverted second operand, bit 1 selects the stored carry as carry-in
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_ADC = 2'b10,
        OP_SBC = 2'b11
    } addc_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } addc_flags_t;
endpackage

// File: rtl/addc_operand_prep.sv
module addc_operand_prep
    import addc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  addc_op_e       op,
    input  logic [W-1:0]   b_in,
    input  logic           carry_flag,
    output logic [W-1:0]   b_eff,
    output logic           cin
);
    always_comb begin
        b_eff = op[0] ? ~b_in : b_in;
        unique case (op)
            OP_ADD: cin = 1'b0;
            OP_SUB: cin = 1'b1;
            OP_ADC: cin = carry_flag;
            OP_SBC: cin = carry_flag;
            default: cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/addc_seg_adder.sv
module addc_seg_adder #(
    parameter int unsigned W   = 64,
    parameter int unsigned SEG = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned NSEG = W / SEG;

    logic [NSEG:0] cy;
    assign cy[0] = cin;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SEG:0] part;
        assign part = {1'b0, x[g*SEG +: SEG]} + {1'b0, y[g*SEG +: SEG]}
                    + {{SEG{1'b0}}, cy[g]};
        assign sum[g*SEG +: SEG] = part[SEG-1:0];
        assign cy[g+1]           = part[SEG];
    end

    assign cout = cy[NSEG];

    initial begin
        seg_div_chk: assert (W % SEG == 0);
    end
endmodule

// File: rtl/addc_flag_gen.sv
module addc_flag_gen
    import addc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y_eff,
    input  logic [W-1:0] sum,
    input  logic         cout,
    output addc_flags_t  flags
);
    always_comb begin
        flags.c = cout;
        flags.z = (sum == '0);
        flags.n = sum[W-1];
        flags.v = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/addc_unit.sv
module addc_unit
    import addc_pkg::*;
#(
    parameter int unsigned W   = DATA_W,
    parameter int unsigned SEG = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic         flag_we_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         valid_o,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         zero_o,
    output logic         neg_o,
    output logic         ovf_o
);
    addc_op_e     op;
    addc_flags_t  flags_q;
    addc_flags_t  flags_d;
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;
    logic [W-1:0] result_q;
    logic         valid_q;

    assign op = addc_op_e'(op_i);

    addc_operand_prep #(.W(W)) u_prep (
        .op         (op),
        .b_in       (b_i),
        .carry_flag (flags_q.c),
        .b_eff      (b_eff),
        .cin        (cin)
    );

    addc_seg_adder #(.W(W), .SEG(SEG)) u_add (
        .x    (a_i),
        .y    (b_eff),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    addc_flag_gen #(.W(W)) u_flags (
        .x     (a_i),
        .y_eff (b_eff),
        .sum   (sum),
        .cout  (cout),
        .flags (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) begin
                result_q <= sum;
                if (flag_we_i) flags_q <= flags_d;
            end
        end
    end

    always_comb begin
        valid_o  = valid_q;
        result_o = result_q;
        carry_o  = flags_q.c;
        zero_o   = flags_q.z;
        neg_o    = flags_q.n;
        ovf_o    = flags_q.v;
    end

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o));
    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && flag_we_i) |=> $stable({carry_o, zero_o, neg_o, ovf_o}));
    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flag_we_i) |=> (zero_o == (result_o == '0)));
    // R6
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flag_we_i) |=> (neg_o == result_o[W-1]));
    // R3
    sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flag_we_i && op_i == 2'b01) |=> (carry_o == ($past(a_i) >= $past(b_i))));
    // R2
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flag_we_i && op_i == 2'b00) |=> (carry_o == (result_o < $past(a_i))));
endmodule

// File: tb/addc_unit_bench.sv
`timescale 1ns/1ps
module addc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        flag_we_i = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        valid_o;
    logic [63:0] result_o;
    logic        carry_o, zero_o, neg_o, ovf_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    addc_unit u_addc_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .flag_we_i(flag_we_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o),
        .neg_o(neg_o), .ovf_o(ovf_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // launch one op, then sample half a period after the registering edge
    task automatic launch(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                          input logic we);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; a_i = a; b_i = b; flag_we_i = we;
        @(negedge clk);
        valid_i = 1'b0; flag_we_i = 1'b0;
    endtask

    task automatic chk_flags(input string tag, input logic c, input logic z,
                             input logic n, input logic v);
        check({tag, " carry"}, {63'd0, carry_o}, {63'd0, c});
        check({tag, " zero"},  {63'd0, zero_o},  {63'd0, z});
        check({tag, " neg"},   {63'd0, neg_o},   {63'd0, n});
        check({tag, " ovf"},   {63'd0, ovf_o},   {63'd0, v});
    endtask

    task automatic t_reset();
        // R1
        check("R1 valid", {63'd0, valid_o}, 64'd0);
        check("R1 result", result_o, 64'd0);
        chk_flags("R1", 0, 0, 0, 0);
    endtask

    task automatic t_add();
        launch(2'b00, 64'd5, 64'd7, 1);
        check("R2 add result", result_o, 64'd12);
        check("R9 valid", {63'd0, valid_o}, 64'd1);
        chk_flags("R2 small", 0, 0, 0, 0);
        launch(2'b00, '1, 64'd1, 1);
        check("R2 wrap result", result_o, 64'd0);
        chk_flags("R2 wrap R6", 1, 1, 0, 0);
        launch(2'b00, 64'h7fff_ffff_ffff_ffff, 64'd1, 1);
        check("R7 add ovf result", result_o, 64'h8000_0000_0000_0000);
        chk_flags("R7 add", 0, 0, 1, 1);
    endtask

    task automatic t_sub();
        launch(2'b01, 64'd10, 64'd3, 1);
        check("R3 sub result", result_o, 64'd7);
        chk_flags("R3 no borrow", 1, 0, 0, 0);
        launch(2'b01, 64'd3, 64'd10, 1);
        check("R3 borrow result", result_o, 64'hffff_ffff_ffff_fff9);
        chk_flags("R3 borrow", 0, 0, 1, 0);
        launch(2'b01, 64'h1234, 64'h1234, 1);
        check("R3 equal result", result_o, 64'd0);
        chk_flags("R3 equal R6", 1, 1, 0, 0);
        launch(2'b01, 64'h8000_0000_0000_0000, 64'd1, 1);
        check("R7 sub ovf result", result_o, 64'h7fff_ffff_ffff_ffff);
        chk_flags("R7 sub", 1, 0, 0, 1);
    endtask

    task automatic t_adc();
        launch(2'b01, 64'd1, 64'd0, 1);            // sets carry
        launch(2'b10, 64'd2, 64'd3, 1);
        check("R4 adc c=1", result_o, 64'd6);
        chk_flags("R4 c=1", 0, 0, 0, 0);
        launch(2'b10, 64'd2, 64'd3, 1);            // carry now 0
        check("R4 adc c=0", result_o, 64'd5);
        launch(2'b00, '1, 64'd1, 1);               // carry 1
        launch(2'b10, '1, 64'd0, 1);
        check("R4 adc carry out", result_o, 64'd0);
        chk_flags("R4 wrap", 1, 1, 0, 0);
    endtask

    task automatic t_sbc();
        launch(2'b01, 64'd1, 64'd0, 1);            // carry 1
        launch(2'b11, 64'd10, 64'd3, 1);
        check("R5 sbc c=1", result_o, 64'd7);
        chk_flags("R5 c=1", 1, 0, 0, 0);
        launch(2'b00, 64'd0, 64'd0, 1);            // carry 0
        launch(2'b11, 64'd10, 64'd3, 1);
        check("R5 sbc c=0", result_o, 64'd6);
        chk_flags("R5 c=0", 1, 0, 0, 0);
        launch(2'b00, 64'd0, 64'd0, 1);            // carry 0
        launch(2'b11, 64'd0, 64'd0, 1);
        check("R5 sbc borrow", result_o, '1);
        chk_flags("R5 borrow", 0, 0, 1, 0);
    endtask

    task automatic t_nowrite();
        launch(2'b00, '1, 64'd1, 1);               // C=1 Z=1 N=0 V=0
        launch(2'b00, 64'h7fff_ffff_ffff_ffff, 64'd1, 0);
        check("R8 result", result_o, 64'h8000_0000_0000_0000);
        chk_flags("R8 held", 1, 1, 0, 0);
        @(negedge clk);
        check("R9 valid low", {63'd0, valid_o}, 64'd0);
        check("R9 result held", result_o, 64'h8000_0000_0000_0000);
        chk_flags("R9 held", 1, 1, 0, 0);
    endtask

    task automatic t_chain(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] d, s;
        logic [63:0]  lo;
        d = x - y;
        s = x + y;
        launch(2'b01, x[63:0], y[63:0], 1);
        lo = result_o;
        launch(2'b11, x[127:64], y[127:64], 1);
        check("R10 sub128", {result_o, lo} == d ? 64'd1 : 64'd0, 64'd1);
        check("R10 sub128 carry", {63'd0, carry_o}, {63'd0, x >= y});
        launch(2'b00, x[63:0], y[63:0], 1);
        lo = result_o;
        launch(2'b10, x[127:64], y[127:64], 1);
        check("R10 add128", {result_o, lo} == s ? 64'd1 : 64'd0, 64'd1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_adc();
        t_sbc();
        t_nowrite();
        t_chain({64'd1, 64'd0}, {64'd0, 64'd1});
        t_chain({64'd5, 64'd3}, {64'd7, 64'd9});
        t_chain({64'hdead_beef_0000_0001, 64'hffff_ffff_ffff_ffff},
                {64'h0123_4567_89ab_cdef, 64'hffff_ffff_ffff_ffff});
        for (int i = 0; i < 8; i++) begin
            logic [127:0] p, q;
            p = {64'h9e37_79b9_7f4a_7c15 * (i + 3), 64'hbf58_476d_1ce4_e5b9 * (i + 1)};
            q = {64'h94d0_49bb_1331_11eb * (i + 5), 64'h2545_f491_4f6c_dd1d * (i + 2)};
            t_chain(p, q);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule